// File: doc/BRIEF.md
# Reset Extension and Sequencing Controller

This block turns three reset sources into a pair of ordered, stretched reset outputs for the rest of a chip. A power-on indication, an external reset pin and a software request each start a reset. The block holds the peripheral reset and the core reset asserted for an extension interval. The interval depends on which source started the reset. Once the interval ends, the peripheral reset is released first and the core reset follows one stage later.

Both asynchronous inputs pass through two-flop synchronizers. Assertion therefore reaches the outputs at once, and release is aligned to the clock. A request that arrives while a sequence is still running restarts the count. The new count uses the length of the highest-priority cause seen so far in that sequence.

A small register port gives software the reset request bit, a sticky cause register and four 16-bit scratch registers. Only power-on clears the scratch registers, so software can use them to carry state across pin and software resets.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While por_n is low, periph_rst_n and core_rst_n are low at once, with no clock edge needed. After por_n rises, periph_rst_n rises on the (POR_LEN+3)-th rising clock edge: two edges for the synchronizer, one to load the counter, then POR_LEN extension cycles.
- R2: After pin_rst_n rises, periph_rst_n rises on the (EXT_LEN+3)-th rising clock edge, provided no other request is pending.
- R3: Writing a word with bit 0 set to address 0 requests a software reset. periph_rst_n is low right after the write edge and rises on the (EXT_LEN+4)-th rising edge counted from the write edge, which is edge 1.
- R4: core_rst_n rises exactly STAGE_LEN cycles after periph_rst_n rises, and is never high while periph_rst_n is low.
- R5: A low level on pin_rst_n drives both outputs low immediately, with no clock edge needed.
- R6: A request that arrives before core_rst_n is released restarts the extension. The length comes from the highest-priority cause seen since the sequence started, with power-on above pin and pin above software. A pin reset during a power-on extension therefore ends POR_LEN+3 edges after the pin is released.
- R7: The software request bit, read as bit 0 of address 0, clears itself once the reset has been taken, and reads 0 after release.
- R8: Address 1 holds a sticky cause register: bit 0 is power-on, bit 1 is pin, bit 2 is software. Power-on sets it to 3'b001. Pin and software resets set their own bits. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged.
- R9: Addresses 4 to 7 are four 16-bit scratch registers that read back what was written. They are cleared to 0 by power-on and keep their contents through pin and software resets.
- R10: Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| core_rst_n | output | 1 | Core reset, active low, released last |

## Verification
The bench measures the exact edge of each release. A synchronizer or counter that is off by one shows up as a release count one cycle short or long.

It re-asserts the pin at every offset from the start of an extension to past the core release. A design that failed to reload its counter would release early at one of those offsets. Pulsing the pin inside a power-on extension checks the priority rule: a design that took the newest cause would release after the short length instead of the long one.

Scratch data is checked across pin, software and power-on resets, which catches registers tied to the wrong reset. Cause bits are checked through write-1-to-clear patterns, which catches a clear that hits the wrong bits.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    PH_HOLD   = 2'd0,
    PH_EXTEND = 2'd1,
    PH_STAGE  = 2'd2,
    PH_RUN    = 2'd3
  } phase_t;

  // Numeric order is the priority order: larger wins.
  typedef enum logic [1:0] {
    CAUSE_SW  = 2'd0,
    CAUSE_PIN = 2'd1,
    CAUSE_POR = 2'd2
  } cause_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int GP_BASE   = 4;

  localparam int STAT_W  = 3;
  localparam int ST_POR  = 0;
  localparam int ST_PIN  = 1;
  localparam int ST_SW   = 2;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic ok
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign ok = sh_q[STAGES-1];

endmodule

// File: rtl/rsc_sequencer.sv
module rsc_sequencer
  import rsc_pkg::*;
#(
  parameter int POR_LEN   = 2097152,
  parameter int EXT_LEN   = 96,
  parameter int STAGE_LEN = 32,
  parameter int CNT_W     = 22
) (
  input  logic clk,
  input  logic por_n,
  input  logic por_ok,
  input  logic pin_ok,
  input  logic sw_req,
  output logic hold,
  output logic periph_en,
  output logic core_en
);

  localparam logic [CNT_W-1:0] POR_LOAD   = CNT_W'(POR_LEN - 1);
  localparam logic [CNT_W-1:0] EXT_LOAD   = CNT_W'(EXT_LEN - 1);
  localparam logic [CNT_W-1:0] STAGE_LOAD = CNT_W'(STAGE_LEN - 1);

  phase_t            phase_q, phase_d;
  cause_t            cause_q, cause_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              req_any;
  cause_t            req_cause;
  logic              cnt_zero;

  always_comb begin
    req_any   = !por_ok || !pin_ok || sw_req;
    req_cause = !por_ok ? CAUSE_POR : (!pin_ok ? CAUSE_PIN : CAUSE_SW);
    cnt_zero  = (cnt_q == '0);
  end

  always_comb begin
    phase_d = phase_q;
    cause_d = cause_q;
    cnt_d   = cnt_q;
    if (req_any) begin
      phase_d = PH_HOLD;
      cnt_d   = '0;
      if (phase_q == PH_RUN || req_cause > cause_q) begin
        cause_d = req_cause;
      end
    end else begin
      case (phase_q)
        PH_HOLD: begin
          phase_d = PH_EXTEND;
          cnt_d   = (cause_q == CAUSE_POR) ? POR_LOAD : EXT_LOAD;
        end
        PH_EXTEND: begin
          if (cnt_zero) begin
            phase_d = PH_STAGE;
            cnt_d   = STAGE_LOAD;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        PH_STAGE: begin
          if (cnt_zero) begin
            phase_d = PH_RUN;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: begin
          phase_d = PH_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_HOLD;
      cause_q <= CAUSE_POR;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cause_q <= cause_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold      = (phase_q == PH_HOLD);
  assign periph_en = (phase_q == PH_STAGE) || (phase_q == PH_RUN);
  assign core_en   = (phase_q == PH_RUN);

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile
  import rsc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int NUM_GP = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              seq_hold,
  input  logic              pin_ok,
  output logic              sw_req
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic              sw_q, sw_d;
  logic [STAT_W-1:0] st_q, st_d;
  logic [DATA_W-1:0] gp_q [NUM_GP];

  // Software request: set by a write, cleared once the sequencer holds.
  always_comb begin
    sw_d = sw_q;
    if (seq_hold && sw_q) begin
      sw_d = 1'b0;
    end
    if (wr_en && wr_addr == A_CTRL && wr_data[0]) begin
      sw_d = 1'b1;
    end
  end

  // Cause bits: write-1-to-clear, event set wins.
  always_comb begin
    st_d = st_q;
    if (wr_en && wr_addr == A_STAT) begin
      st_d = st_q & ~wr_data[STAT_W-1:0];
    end
    if (!pin_ok) begin
      st_d[ST_PIN] = 1'b1;
    end
    if (sw_q) begin
      st_d[ST_SW] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_q <= 1'b0;
      st_q <= STAT_W'(1) << ST_POR;
    end else begin
      sw_q <= sw_d;
      st_q <= st_d;
    end
  end

  for (genvar gi = 0; gi < NUM_GP; gi++) begin : g_gp
    localparam logic [ADDR_W-1:0] A_GP = ADDR_W'(GP_BASE + gi);
    logic gp_we;
    assign gp_we = wr_en && (wr_addr == A_GP);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        gp_q[gi] <= '0;
      end else if (gp_we) begin
        gp_q[gi] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) begin
      rd_data[0] = sw_q;
    end
    if (rd_addr == A_STAT) begin
      rd_data[STAT_W-1:0] = st_q;
    end
    for (int i = 0; i < NUM_GP; i++) begin
      if (rd_addr == ADDR_W'(GP_BASE + i)) begin
        rd_data = gp_q[i];
      end
    end
  end

  assign sw_req = sw_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int POR_LEN   = 2097152,
  parameter int EXT_LEN   = 96,
  parameter int STAGE_LEN = 32,
  parameter int SYNC_LEN  = 2,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16,
  parameter int NUM_GP    = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              periph_rst_n,
  output logic              core_rst_n
);

  localparam int MAX_A   = (POR_LEN > EXT_LEN) ? POR_LEN : EXT_LEN;
  localparam int MAX_LEN = (MAX_A > STAGE_LEN) ? MAX_A : STAGE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic por_ok;
  logic pin_ok;
  logic sw_q;
  logic seq_hold;
  logic seq_periph;
  logic seq_core;

  rsc_sync #(.STAGES(SYNC_LEN)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .ok     (por_ok)
  );

  rsc_sync #(.STAGES(SYNC_LEN)) u_pin_sync (
    .clk    (clk),
    .arst_n (pin_rst_n),
    .ok     (pin_ok)
  );

  rsc_sequencer #(
    .POR_LEN   (POR_LEN),
    .EXT_LEN   (EXT_LEN),
    .STAGE_LEN (STAGE_LEN),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .por_ok    (por_ok),
    .pin_ok    (pin_ok),
    .sw_req    (sw_q),
    .hold      (seq_hold),
    .periph_en (seq_periph),
    .core_en   (seq_core)
  );

  rsc_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_GP (NUM_GP)
  ) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .seq_hold (seq_hold),
    .pin_ok   (pin_ok),
    .sw_req   (sw_q)
  );

  // Asynchronous pin assertion and a fresh software request reach the outputs directly.
  assign periph_rst_n = seq_periph & pin_ok & ~sw_q;
  assign core_rst_n   = seq_core   & pin_ok & ~sw_q;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int STAGE_LEN = 32
) (
  input logic clk,
  input logic por_n,
  input logic pin_rst_n,
  input logic periph_rst_n,
  input logic core_rst_n,
  input logic sw_req
);

  localparam int GW = $clog2(STAGE_LEN + 2) + 1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      gap_q <= '0;
    end else if (!periph_rst_n) begin
      gap_q <= '0;
    end else if (!core_rst_n && gap_q != '1) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  AST_CORE_UNDER_PERIPH: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_n |-> periph_rst_n); // R4

  AST_PERIPH_LEADS: assert property (@(posedge clk) disable iff (!por_n)
    $rose(periph_rst_n) |-> !core_rst_n); // R4

  AST_STAGE_GAP: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> (gap_q == GW'(STAGE_LEN))); // R4

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    !pin_rst_n |-> (!periph_rst_n && !core_rst_n)); // R5

  AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    $rose(periph_rst_n) |-> !sw_req); // R7

endmodule

bind rst_seq_ctrl rsc_checker #(.STAGE_LEN(STAGE_LEN)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .pin_rst_n    (pin_rst_n),
  .periph_rst_n (periph_rst_n),
  .core_rst_n   (core_rst_n),
  .sw_req       (sw_q)
);

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;

  localparam int POR_L = 50;
  localparam int EXT_L = 12;
  localparam int STG_L = 4;

  logic        clk;
  logic        por_n;
  logic        pin_rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        periph_rst_n;
  logic        core_rst_n;

  int n_cmp;
  int n_bad;
  bit done;
  logic [15:0] pat [4];

  rst_seq_ctrl #(
    .POR_LEN   (POR_L),
    .EXT_LEN   (EXT_L),
    .STAGE_LEN (STG_L)
  ) u0 (
    .clk          (clk),
    .por_n        (por_n),
    .pin_rst_n    (pin_rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .periph_rst_n (periph_rst_n),
    .core_rst_n   (core_rst_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts rising edges from the current negedge until each output rises.
  task automatic measure(output int np, output int nc);
    np = 0; nc = 0;
    for (int k = 1; k <= 5000 && nc == 0; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (periph_rst_n && np == 0) np = k;
      if (core_rst_n && nc == 0) nc = k;
    end
  endtask

  task automatic pin_pulse();
    @(negedge clk);
    pin_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    pin_rst_n = 1'b1;
  endtask

  // Issues the software request; returns at the negedge after the write edge.
  task automatic sw_kick();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int np, nc;
    logic [15:0] d;
    n_cmp = 0; n_bad = 0; done = 0;
    por_n = 1'b0; pin_rst_n = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int i = 0; i < 4; i++) pat[i] = (16'h1357 * 16'(i + 1)) ^ 16'hA5C3;

    repeat (3) @(negedge clk);
    pin_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 periph held in power-on", 32'(periph_rst_n), 0);
    chk("R1 core held in power-on", 32'(core_rst_n), 0);
    rd(3'd1, d); chk("R8 status after power-on", 32'(d), 32'h1);
    rd(3'd0, d); chk("R7 request bit reset", 32'(d), 0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R9 scratch clear at power-on", 32'(d), 0);
    end

    por_n = 1'b1;
    measure(np, nc);
    chk("R1 power-on release edge", 32'(np), 32'(POR_L + 3));
    chk("R4 core after power-on", 32'(nc), 32'(POR_L + 3 + STG_L));

    for (int i = 0; i < 4; i++) wr(3'(4 + i), pat[i]);
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R9 scratch readback", 32'(d), 32'(pat[i]));
    end
    rd(3'd2, d); chk("R10 unmapped addr 2", 32'(d), 0);
    rd(3'd3, d); chk("R10 unmapped addr 3", 32'(d), 0);

    // Pin reset, immediate assertion and release count
    @(negedge clk);
    pin_rst_n = 1'b0;
    #1;
    chk("R5 periph immediate on pin", 32'(periph_rst_n), 0);
    chk("R5 core immediate on pin", 32'(core_rst_n), 0);
    repeat (2) @(negedge clk);
    pin_rst_n = 1'b1;
    measure(np, nc);
    chk("R2 pin release edge", 32'(np), 32'(EXT_L + 3));
    chk("R4 core after pin", 32'(nc), 32'(EXT_L + 3 + STG_L));
    rd(3'd1, d); chk("R8 status after pin", 32'(d), 32'h3);
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R9 scratch kept over pin", 32'(d), 32'(pat[i]));
    end

    wr(3'd1, 16'h0002);
    rd(3'd1, d); chk("R8 clear pin bit only", 32'(d), 32'h1);
    wr(3'd1, 16'h0000);
    rd(3'd1, d); chk("R8 zero write no effect", 32'(d), 32'h1);
    wr(3'd1, 16'h0001);
    rd(3'd1, d); chk("R8 clear power-on bit", 32'(d), 32'h0);

    // Software reset
    sw_kick();
    #1;
    chk("R3 periph low after write", 32'(periph_rst_n), 0);
    measure(np, nc);
    chk("R3 software release edge", 32'(np + 1), 32'(EXT_L + 4));
    chk("R4 core after software", 32'(nc + 1), 32'(EXT_L + 4 + STG_L));
    rd(3'd0, d); chk("R7 request bit self-cleared", 32'(d), 0);
    rd(3'd1, d); chk("R8 status after software", 32'(d), 32'h4);
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R9 scratch kept over software", 32'(d), 32'(pat[i]));
    end

    // Restart sweep: second pin pulse at every offset
    for (int off = 0; off <= EXT_L + STG_L + 4; off++) begin
      pin_pulse();
      repeat (off) @(negedge clk);
      pin_pulse();
      measure(np, nc);
      chk("R6 pin restart release", 32'(np), 32'(EXT_L + 3));
    end

    // Software request during a pin extension keeps the pin length
    pin_pulse();
    repeat (4) @(negedge clk);
    sw_kick();
    measure(np, nc);
    chk("R6 software during pin extension", 32'(np + 1), 32'(EXT_L + 4));

    // Pin during a power-on extension keeps the power-on length
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R1 periph immediate on power-on", 32'(periph_rst_n), 0);
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (10) @(negedge clk);
    pin_pulse();
    measure(np, nc);
    chk("R6 pin inside power-on extension", 32'(np), 32'(POR_L + 3));
    rd(3'd1, d); chk("R8 status power-on then pin", 32'(d), 32'h3);
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R9 scratch cleared by power-on", 32'(d), 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule